// File: doc/BRIEF.md
# Write-Update Snooping Line Coherence Controller

This block keeps the coherence state of one cached line for a snooping protocol in which a store to a shared line is broadcast and patches every other copy in place rather than killing it. A line is invalid, exclusive-clean, shared-clean, exclusive-modified or shared-modified. The shared-modified holder owns the data: its broadcasts reach peer caches but not memory, so it must write the line back when it drops it.

On the processor side the controller takes load, store and evict requests and answers each with a one-cycle done pulse. On the bus side it raises read, update and write-back cycles and samples the wired shared-status signal in the grant cycle, which decides whether the line ends exclusive or shared. As a snooper it answers read and update cycles from peers on the same line. It raises shared status, offers to supply dirty data in place of memory, and tells the data array to take broadcast store data. The tag compare, data array, bus arbiter and memory sit outside the block.

Top module: `coh_ctrl`

## Requirements
- R1: After reset, and at once while reset is asserted, `line_state` is 0 (invalid), `bus_req`, `cpu_done` and `snp_shared_out` are low and `bus_cmd` is 0 (none). State codes are 0 invalid, 1 exclusive-clean, 2 shared-clean, 3 exclusive-modified, 4 shared-modified. Bus command codes are 0 none, 1 read, 2 update, 3 write-back. Processor operation codes are 0 load, 1 store, 2 evict.
- R2: A load to a valid line completes with no bus request and leaves the state unchanged.
- R3: A load to an invalid line issues a read (1). If `bus_shared_in` is low in the grant cycle the line becomes exclusive-clean (1), otherwise shared-clean (2).
- R4: A store to an exclusive-clean or exclusive-modified line issues no bus request and leaves the line exclusive-modified (3).
- R5: A store to a shared-clean or shared-modified line issues an update (2) with `bus_wdata` equal to the store data. If shared status is high at grant the line becomes shared-modified (4), otherwise exclusive-modified (3).
- R6: A store to an invalid line issues a read. With shared status low at that grant it ends exclusive-modified after that one cycle. With it high it then issues an update, resolved as in R5.
- R7: Evicting a modified line (3 or 4) issues a write-back (3) and then leaves the line invalid. Evicting a clean line makes it invalid with no bus request.
- R8: A snooped read (`snp_valid`, `snp_hit`, command 1) to a valid line raises `snp_shared_out` in the same cycle. It raises `snp_supply` when the line is modified, and moves exclusive-clean to shared-clean and exclusive-modified to shared-modified. Shared states keep their state.
- R9: A snooped update (command 2) to a valid line raises `snp_shared_out` and `snp_upd_we` in the same cycle and leaves the line shared-clean, so a shared-modified holder gives up ownership.
- R10: A snoop with `snp_hit` low, to an invalid line, or carrying a write-back command raises no snoop output and changes no state.
- R11: A processor request is not taken in a cycle with a snoop hit. The snoop acts first, and the request is decided on the state the snoop left.
- R12: `cpu_done` is high for exactly one cycle per request. The requester drops `cpu_req` in the cycle it sees `cpu_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_op | input | 2 | Operation: 0 load, 1 store, 2 evict |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus cycle wanted |
| bus_cmd | output | 2 | Bus command: 0 none, 1 read, 2 update, 3 write-back |
| bus_wdata | output | DATA_W | Data broadcast with an update |
| bus_gnt | input | 1 | Bus granted; the cycle takes place in this clock |
| bus_shared_in | input | 1 | Wired shared status from peers, sampled at grant |
| snp_valid | input | 1 | A peer bus cycle is being observed |
| snp_hit | input | 1 | The observed address matches this line |
| snp_cmd | input | 2 | Command of the observed cycle, same coding as `bus_cmd` |
| snp_shared_out | output | 1 | This cache holds the observed line |
| snp_supply | output | 1 | This cache will supply the line instead of memory |
| snp_upd_we | output | 1 | Write broadcast data into the local copy |
| line_state | output | 3 | Current coherence state code |

## Verification
A wrong internal state shows at the ports on the next request that touches the line. A lost exclusive state turns a local store into an update cycle, a wrongly kept one lets a store stay silent. A lost dirty state drops the write-back on eviction and the supply offer to a snooped read. These differences appear in the cycle after the request is taken, or in the same cycle as the snoop. The bench walks a chain of operations in which each one starts from the state the last one left. Every transition is therefore judged both by `line_state` and by the bus traffic the following step produces.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_EC  = 3'd1,
    LS_SC  = 3'd2,
    LS_EM  = 3'd3,
    LS_SM  = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_e;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_EVICT = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_UPD,
    PH_WB,
    PH_DONE
  } phase_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == LS_EM) || (s == LS_SM);
  endfunction

  function automatic logic is_shared(line_st_e s);
    return (s == LS_SC) || (s == LS_SM);
  endfunction

endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
(
  input  line_st_e   cur_st,
  input  logic       snp_valid,
  input  logic       snp_hit,
  input  logic [1:0] snp_cmd,
  output logic       snp_busy,
  output logic       shared_out,
  output logic       supply,
  output logic       upd_we,
  output logic       apply,
  output line_st_e   next_st
);

  logic match;
  logic is_rd;
  logic is_up;

  assign match    = snp_valid && snp_hit;
  assign snp_busy = match;
  assign is_rd    = match && (cur_st != LS_INV) && (snp_cmd == BC_READ);
  assign is_up    = match && (cur_st != LS_INV) && (snp_cmd == BC_UPDATE);

  assign shared_out = is_rd || is_up;
  assign supply     = is_rd && is_dirty(cur_st);
  assign upd_we     = is_up;
  assign apply      = is_rd || is_up;

  always_comb begin
    next_st = cur_st;
    if (is_up) begin
      next_st = LS_SC;
    end else if (is_rd) begin
      unique case (cur_st)
        LS_EC:   next_st = LS_SC;
        LS_EM:   next_st = LS_SM;
        default: next_st = cur_st;
      endcase
    end
  end

endmodule

// File: rtl/coh_seq.sv
module coh_seq
  import coh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              snp_busy,
  input  line_st_e          cur_st,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              st_wr,
  output line_st_e          st_val
);

  phase_e            ph_q, ph_d;
  logic              store_q, store_d;
  logic              wbuf_en;
  logic [DATA_W-1:0] wbuf_q;

  always_comb begin
    ph_d    = ph_q;
    store_d = store_q;
    wbuf_en = 1'b0;
    st_wr   = 1'b0;
    st_val  = cur_st;
    unique case (ph_q)
      PH_IDLE: begin
        if (cpu_req && !snp_busy) begin
          if (cpu_op == OP_STORE) begin
            wbuf_en = 1'b1;
            store_d = 1'b1;
            if ((cur_st == LS_EC) || (cur_st == LS_EM)) begin
              st_wr  = 1'b1;
              st_val = LS_EM;
              ph_d   = PH_DONE;
            end else if (is_shared(cur_st)) begin
              ph_d = PH_UPD;
            end else begin
              ph_d = PH_RD;
            end
          end else if (cpu_op == OP_EVICT) begin
            store_d = 1'b0;
            if (is_dirty(cur_st)) begin
              ph_d = PH_WB;
            end else begin
              st_wr  = 1'b1;
              st_val = LS_INV;
              ph_d   = PH_DONE;
            end
          end else begin
            store_d = 1'b0;
            ph_d    = (cur_st != LS_INV) ? PH_DONE : PH_RD;
          end
        end
      end
      PH_RD: begin
        if (bus_gnt) begin
          st_wr = 1'b1;
          if (store_q) begin
            st_val = bus_shared_in ? LS_SC : LS_EM;
            ph_d   = bus_shared_in ? PH_UPD : PH_DONE;
          end else begin
            st_val = bus_shared_in ? LS_SC : LS_EC;
            ph_d   = PH_DONE;
          end
        end
      end
      PH_UPD: begin
        if (bus_gnt) begin
          st_wr  = 1'b1;
          st_val = bus_shared_in ? LS_SM : LS_EM;
          ph_d   = PH_DONE;
        end
      end
      PH_WB: begin
        if (bus_gnt) begin
          st_wr  = 1'b1;
          st_val = LS_INV;
          ph_d   = PH_DONE;
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      store_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      store_q <= store_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wbuf_en) begin
      wbuf_q <= cpu_wdata;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_RD:   bus_cmd = BC_READ;
      PH_UPD:  bus_cmd = BC_UPDATE;
      PH_WB:   bus_cmd = BC_WRBACK;
      default: bus_cmd = BC_NONE;
    endcase
  end

  assign bus_req   = (ph_q == PH_RD) || (ph_q == PH_UPD) || (ph_q == PH_WB);
  assign cpu_done  = (ph_q == PH_DONE);
  assign bus_wdata = wbuf_q;

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic              snp_hit,
  input  logic [1:0]        snp_cmd,
  output logic              snp_shared_out,
  output logic              snp_supply,
  output logic              snp_upd_we,
  output logic [2:0]        line_state
);

  logic     rst_sync_n;
  line_st_e st_q, st_d;
  logic     st_en;
  logic     seq_wr;
  line_st_e seq_val;
  logic     snp_apply;
  line_st_e snp_next;
  logic     snp_busy;

  coh_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  coh_snoop u_snoop (
    .cur_st     (st_q),
    .snp_valid  (snp_valid),
    .snp_hit    (snp_hit),
    .snp_cmd    (snp_cmd),
    .snp_busy   (snp_busy),
    .shared_out (snp_shared_out),
    .supply     (snp_supply),
    .upd_we     (snp_upd_we),
    .apply      (snp_apply),
    .next_st    (snp_next)
  );

  coh_seq #(.DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cpu_req       (cpu_req),
    .cpu_op        (cpu_op),
    .cpu_wdata     (cpu_wdata),
    .snp_busy      (snp_busy),
    .cur_st        (st_q),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .bus_wdata     (bus_wdata),
    .st_wr         (seq_wr),
    .st_val        (seq_val)
  );

  // Own bus cycles win; the arbiter keeps peer snoops out of our grant cycle.
  always_comb begin
    st_d  = st_q;
    st_en = seq_wr || snp_apply;
    if (seq_wr) begin
      st_d = seq_val;
    end else if (snp_apply) begin
      st_d = snp_next;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= LS_INV;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign line_state = st_q;

endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bus_req,
  input logic [1:0] bus_cmd,
  input logic       bus_gnt,
  input logic       snp_valid,
  input logic       snp_hit,
  input logic [1:0] snp_cmd,
  input logic       snp_shared_out,
  input logic       snp_supply,
  input logic       snp_upd_we,
  input logic [2:0] line_state
);

  logic own_grant;
  assign own_grant = bus_req && bus_gnt;

  p_idle_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> bus_cmd == 2'd0);

  p_read_only_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd1) |-> line_state == 3'd0);

  p_update_only_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd2) |-> (line_state == 3'd2 || line_state == 3'd4));

  p_wb_only_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd3) |-> (line_state == 3'd3 || line_state == 3'd4));

  p_wb_ends_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_grant && bus_cmd == 2'd3) |=> line_state == 3'd0);

  p_supply_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_shared_out && (line_state == 3'd3 || line_state == 3'd4)));

  p_read_demotes_ec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_hit && snp_cmd == 2'd1 && line_state == 3'd1 && !own_grant)
    |=> line_state == 3'd2);

  p_update_to_sc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_upd_we && !own_grant) |=> line_state == 3'd2);

  p_shared_needs_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_out |-> (snp_valid && snp_hit && line_state != 3'd0));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

endmodule

bind coh_ctrl coh_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_done       (cpu_done),
  .bus_req        (bus_req),
  .bus_cmd        (bus_cmd),
  .bus_gnt        (bus_gnt),
  .snp_valid      (snp_valid),
  .snp_hit        (snp_hit),
  .snp_cmd        (snp_cmd),
  .snp_shared_out (snp_shared_out),
  .snp_supply     (snp_supply),
  .snp_upd_we     (snp_upd_we),
  .line_state     (line_state)
);

// File: tb/coh_ctrl_tb.sv
module coh_ctrl_tb;

  localparam int DW = 32;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req;
  logic [1:0]    cpu_op;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_done;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt;
  logic          bus_shared_in;
  logic          snp_valid;
  logic          snp_hit;
  logic [1:0]    snp_cmd;
  logic          snp_shared_out;
  logic          snp_supply;
  logic          snp_upd_we;
  logic [2:0]    line_state;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  coh_ctrl #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_hit(snp_hit),
    .snp_cmd(snp_cmd), .snp_shared_out(snp_shared_out), .snp_supply(snp_supply),
    .snp_upd_we(snp_upd_we), .line_state(line_state)
  );

  // Fields: [21:18] req, [17] snoop, [16:15] op or snoop cmd, [14] shared at
  // first grant, [13] shared at second grant, [12:11] bus cycles, [10:9] first
  // cmd, [8:7] second cmd, [6:4] end state, [3] shared_out, [2] supply, [1] upd_we.
  // Each step starts from the state the previous one left.
  localparam logic [21:0] VEC [NV] = '{
    {4'd3,  1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 load miss alone
    {4'd4,  1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 store on EC
    {4'd8,  1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 snoop read on EM
    {4'd5,  1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd2, 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 store on SM, shared
    {4'd9,  1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 update on SM
    {4'd5,  1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 2'd2, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 store on SC, alone
    {4'd4,  1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 store on EM
    {4'd7,  1'b0, 2'd2, 1'b0, 1'b0, 2'd1, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 evict EM
    {4'd10, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 snoop on invalid
    {4'd6,  1'b0, 2'd1, 1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 store miss, shared
    {4'd7,  1'b0, 2'd2, 1'b0, 1'b0, 2'd1, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 evict SM
    {4'd3,  1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 2'd1, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 load miss shared
    {4'd2,  1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 load hit
    {4'd8,  1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 snoop read on SC
    {4'd7,  1'b0, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 evict clean
    {4'd6,  1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 store miss alone
    {4'd10, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 peer write-back
    {4'd7,  1'b0, 2'd2, 1'b0, 1'b0, 2'd1, 2'd3, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 evict EM
    {4'd6,  1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 2'd1, 2'd2, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 shared read, lone update
    {4'd9,  1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0}  // R9 update on EM
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cpu(input logic [1:0] op, input logic [DW-1:0] wd,
                         input logic sh1, input logic sh2,
                         output int n, output logic [1:0] c1, output logic [1:0] c2,
                         output logic wd_ok, output logic tmo);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_wdata = wd;
    n = 0; c1 = 2'd0; c2 = 2'd0; wd_ok = 1'b1; tmo = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared_in = 1'b0;
      if (cpu_done) begin
        tmo = 1'b0;
        break;
      end
      if (bus_req) begin
        if (n == 0) c1 = bus_cmd; else c2 = bus_cmd;
        if (bus_cmd == 2'd2 && bus_wdata != wd) wd_ok = 1'b0;
        bus_shared_in = (n == 0) ? sh1 : sh2;
        bus_gnt = 1'b1;
        n++;
      end
    end
    cpu_req = 1'b0;
  endtask

  task automatic run_snoop(input logic [1:0] cmd, input logic hit,
                           output logic sh, output logic sup, output logic upd);
    @(negedge clk);
    snp_valid = 1'b1; snp_hit = hit; snp_cmd = cmd;
    #1;
    sh = snp_shared_out; sup = snp_supply; upd = snp_upd_we;
    @(negedge clk);
    snp_valid = 1'b0; snp_hit = 1'b0; snp_cmd = 2'd0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int         n;
    logic [1:0] c1, c2;
    logic       wd_ok, tmo, sh, sup, upd;
    string      rq;

    rst_n = 1'b0; cpu_req = 1'b0; cpu_op = 2'd0; cpu_wdata = '0;
    bus_gnt = 1'b0; bus_shared_in = 1'b0;
    snp_valid = 1'b0; snp_hit = 1'b0; snp_cmd = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(line_state == 3'd0, "R1", "reset state", 32'(line_state), 0);
    check(!bus_req && bus_cmd == 2'd0 && !cpu_done, "R1", "reset bus/done",
          {28'd0, bus_req, cpu_done, bus_cmd}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v  = VEC[i];
      rq = $sformatf("R%0d step %0d", v[21:18], i);
      if (v[17]) begin
        run_snoop(v[16:15], 1'b1, sh, sup, upd);
        check({sh, sup, upd} == v[3:1], rq, "snoop outputs", {29'd0, sh, sup, upd}, {29'd0, v[3:1]});
        check(line_state == v[6:4], rq, "state after snoop", 32'(line_state), 32'(v[6:4]));
      end else begin
        run_cpu(v[16:15], 32'hA5000000 + 32'(i), v[14], v[13], n, c1, c2, wd_ok, tmo);
        check(!tmo, rq, "completion", 32'(tmo), 0);
        check(n == int'(v[12:11]) && c1 == v[10:9] && c2 == v[8:7], rq, "bus cycles",
              {26'd0, 2'(n), c1, c2}, {26'd0, v[12:7]});
        check(wd_ok, rq, "update data", 32'(wd_ok), 1);
        check(line_state == v[6:4], rq, "end state", 32'(line_state), 32'(v[6:4]));
      end
    end

    // Move to EC: evict SC, then lone load miss.
    run_cpu(2'd2, '0, 1'b0, 1'b0, n, c1, c2, wd_ok, tmo);
    run_cpu(2'd0, '0, 1'b0, 1'b0, n, c1, c2, wd_ok, tmo);
    check(line_state == 3'd1, "R3", "setup EC", 32'(line_state), 1);

    // R10: snoop read with no address match
    run_snoop(2'd1, 1'b0, sh, sup, upd);
    check({sh, sup, upd} == 3'b000, "R10", "no-hit outputs", {29'd0, sh, sup, upd}, 0);
    check(line_state == 3'd1, "R10", "no-hit state", 32'(line_state), 1);

    // R11: store and snoop read in the same cycle on an EC line
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_wdata = 32'h5A5A0001;
    snp_valid = 1'b1; snp_hit = 1'b1; snp_cmd = 2'd1;
    @(negedge clk);
    snp_valid = 1'b0; snp_hit = 1'b0; snp_cmd = 2'd0;
    check(line_state == 3'd2, "R11", "snoop first", 32'(line_state), 2);
    check(!bus_req && !cpu_done, "R11", "request held", {30'd0, bus_req, cpu_done}, 0);
    @(negedge clk);
    check(bus_req && bus_cmd == 2'd2, "R11", "store became update",
          {29'd0, bus_req, bus_cmd}, {29'd0, 1'b1, 2'd2});
    check(bus_wdata == 32'h5A5A0001, "R5", "held update data", bus_wdata, 32'h5A5A0001);
    bus_gnt = 1'b1; bus_shared_in = 1'b0;
    @(negedge clk);
    bus_gnt = 1'b0;
    check(cpu_done, "R12", "done after grant", 32'(cpu_done), 1);
    check(line_state == 3'd3, "R5", "lone update to EM", 32'(line_state), 3);
    cpu_req = 1'b0;
    @(negedge clk);
    check(!cpu_done, "R12", "done one cycle", 32'(cpu_done), 0);

    // R1: reset in the middle of a pending write-back
    cpu_req = 1'b1; cpu_op = 2'd2;
    @(negedge clk);
    check(bus_req && bus_cmd == 2'd3, "R7", "write-back pending",
          {29'd0, bus_req, bus_cmd}, {29'd0, 1'b1, 2'd3});
    rst_n = 1'b0;
    #1;
    check(line_state == 3'd0 && !bus_req, "R1", "async reset", {28'd0, bus_req, line_state}, 0);
    cpu_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(line_state == 3'd0 && !bus_req && bus_cmd == 2'd0, "R1", "after release",
          {27'd0, bus_req, bus_cmd, line_state}, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule